// File: doc/BRIEF.md
# Character Display Address Counter with Row-Wrapped Scrolling

This block keeps the address state of a two-row character display controller. A single address counter points into either the display memory or the character-pattern memory. It moves up or down by one after every data-register access, in the direction that the last entry-mode command selected. A display-start register holds the column that is shown at the left edge of the panel. It scrolls both rows together, either by an explicit shift command or, when auto-shift is on, together with each data access.

The display memory is split into two rows of 40 locations. Row 0 lives at 00h–27h and row 1 at 40h–67h. Every step of the counter and every scroll wraps inside that layout, never through the linear 7-bit range. A refresh scanner presents a row and a column and receives, in the same cycle, the display-memory address shown there under the current scroll offset. The cursor output marks the location that the counter addresses whenever the display memory is selected.

Top module: `dd_addr_counter`

## Requirements
- R1: After reset the address is 00h in display memory (`mem_is_cg`=0), the cursor is on at 00h, and the scroll offset is 0, so the scan address for row 0, column 0 is 00h.
- R2: In display memory, a data access with direction up adds one to the column. Bit 6 is the row and bits 5:0 are the column. Going up from 27h gives 40h, and going up from 67h gives 00h.
- R3: In display memory, a data access with direction down subtracts one from the column. Going down from 40h gives 27h, and going down from 00h gives 67h.
- R4: With pattern memory selected, the counter steps over a plain 6-bit range 00h–3Fh and wraps at both ends. Bit 6 stays 0 and no scrolling happens.
- R5: A set-address command with `set_addr_cg`=1 loads bits 5:0 and selects pattern memory. With `set_addr_cg`=0 it selects display memory and keeps bit 6 as the row. A column of 40 or more is reduced by 40.
- R6: Clear sets the address to 00h in display memory, sets the scroll offset to 0 and sets the direction to up. Home does the same but leaves the direction unchanged.
- R7: When auto-shift is on and display memory is selected, each data access also moves the scroll offset modulo 40. It goes up by one with direction up and down by one with direction down. In pattern memory the offset is left as it is.
- R8: A shift command with `shift_display`=0 moves the address one step as in R2/R4, up when `shift_right`=1 and down otherwise. With `shift_display`=1 it moves the scroll offset modulo 40, down when `shift_right`=1 and up otherwise, and leaves the address alone.
- R9: The scan address is the row base (00h or 40h) plus (offset + `scan_col`) mod 40. It is combinational from the current offset.
- R10: `cursor_on` is 1 and `cursor_addr` equals `mem_addr` in display memory. In pattern memory `cursor_on` is 0 and `cursor_addr` is 00h.
- R11: An entry-mode command changes only the direction and auto-shift settings. The address and the scroll offset keep their values.
- R12: All commands take effect at the next clock edge. If several strobes are high together, priority is clear, home, set address, entry mode, shift, data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_addr_stb | input | 1 | Load the address counter |
| set_addr_cg | input | 1 | 1 selects pattern memory for the load |
| set_addr_val | input | 7 | Address to load |
| clear_stb | input | 1 | Clear command |
| home_stb | input | 1 | Home command |
| entry_stb | input | 1 | Entry-mode command |
| entry_up | input | 1 | Direction for data accesses (1 = up) |
| entry_shift | input | 1 | Auto-shift of the display on data access |
| shift_stb | input | 1 | Shift command |
| shift_display | input | 1 | 1 scrolls the display, 0 moves the cursor |
| shift_right | input | 1 | Shift direction |
| data_stb | input | 1 | One data-register access has completed |
| scan_row | input | 1 | Row requested by the refresh scanner |
| scan_col | input | 6 | Column requested by the refresh scanner (0–39) |
| mem_addr | output | 7 | Current counter address |
| mem_is_cg | output | 1 | Counter addresses pattern memory |
| cursor_addr | output | 7 | Cursor location in display memory |
| cursor_on | output | 1 | Cursor location is valid |
| scan_addr | output | 7 | Display-memory address for the scanned position |

## Verification
The assertions assume that at most one command strobe is high in any cycle. One of them checks this on the inputs. They also assume that the scanner asks only for columns below 40. The random stimulus picks exactly one command, or none, per cycle and draws `scan_col` from 0–39. Directed cases take the counter to every row edge and to the pattern-memory ends before stepping across them. The priority rule therefore only matters outside that contract, and it is recorded for completeness.

// File: rtl/dd_addr_pkg.sv
package dd_addr_pkg;

    // Geometry of the split display memory
    localparam int ROW_LEN   = 40;
    localparam int ADDR_W    = 7;
    localparam int COL_W     = ADDR_W - 1;

    // Decoded command, one per cycle after priority resolution
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_CLEAR,
        CMD_HOME,
        CMD_SET,
        CMD_ENTRY,
        CMD_SHIFT_CUR,
        CMD_SHIFT_DISP,
        CMD_DATA
    } cmd_e;

    // Entry-mode settings
    typedef struct packed {
        logic up;
        logic auto_shift;
    } entry_t;

endpackage

// File: rtl/dd_cmd_decode.sv
module dd_cmd_decode
    import dd_addr_pkg::*;
(
    input  logic clear_stb,
    input  logic home_stb,
    input  logic set_addr_stb,
    input  logic entry_stb,
    input  logic shift_stb,
    input  logic shift_display,
    input  logic data_stb,
    output cmd_e cmd
);

    always_comb begin
        if (clear_stb)          cmd = CMD_CLEAR;
        else if (home_stb)      cmd = CMD_HOME;
        else if (set_addr_stb)  cmd = CMD_SET;
        else if (entry_stb)     cmd = CMD_ENTRY;
        else if (shift_stb)     cmd = shift_display ? CMD_SHIFT_DISP : CMD_SHIFT_CUR;
        else if (data_stb)      cmd = CMD_DATA;
        else                    cmd = CMD_NONE;
    end

endmodule

// File: rtl/dd_ac_unit.sv
module dd_ac_unit
    import dd_addr_pkg::*;
#(
    parameter int ROWS_LEN = ROW_LEN,
    parameter int AW       = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_e          cmd,
    input  logic [AW-1:0] load_val,
    input  logic          load_cg,
    input  logic          shift_right,
    input  logic          new_up,
    input  logic          new_shift,
    output logic [AW-1:0] ac_q,
    output logic          is_cg_q,
    output entry_t        entry_q
);

    localparam int CW = AW - 1;
    localparam logic [CW-1:0] LAST = CW'(ROWS_LEN - 1);
    localparam logic [CW-1:0] SPAN = CW'(ROWS_LEN);

    logic          step_up;
    logic [AW-1:0] step_val;
    logic [CW-1:0] col;
    logic          row;
    logic [CW-1:0] fold_col;

    assign col = ac_q[CW-1:0];
    assign row = ac_q[AW-1];
    assign step_up = (cmd == CMD_SHIFT_CUR) ? shift_right : entry_q.up;
    assign fold_col = (load_val[CW-1:0] >= SPAN) ? load_val[CW-1:0] - SPAN
                                                 : load_val[CW-1:0];

    // One-location move: plain in pattern memory, row-windowed in display memory
    always_comb begin
        if (is_cg_q) begin
            step_val = step_up ? {1'b0, col + 1'b1} : {1'b0, col - 1'b1};
        end else if (step_up) begin
            step_val = (col == LAST) ? {~row, {CW{1'b0}}} : {row, col + 1'b1};
        end else begin
            step_val = (col == '0) ? {~row, LAST} : {row, col - 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ac_q    <= '0;
            is_cg_q <= 1'b0;
            entry_q <= '{up: 1'b1, auto_shift: 1'b0};
        end else begin
            case (cmd)
                CMD_CLEAR: begin
                    ac_q       <= '0;
                    is_cg_q    <= 1'b0;
                    entry_q.up <= 1'b1;
                end
                CMD_HOME: begin
                    ac_q    <= '0;
                    is_cg_q <= 1'b0;
                end
                CMD_SET: begin
                    is_cg_q <= load_cg;
                    ac_q    <= load_cg ? {1'b0, load_val[CW-1:0]}
                                       : {load_val[AW-1], fold_col};
                end
                CMD_ENTRY: begin
                    entry_q <= '{up: new_up, auto_shift: new_shift};
                end
                CMD_SHIFT_CUR, CMD_DATA: begin
                    ac_q <= step_val;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dd_start_unit.sv
module dd_start_unit
    import dd_addr_pkg::*;
#(
    parameter int ROWS_LEN = ROW_LEN,
    parameter int CW       = COL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_e          cmd,
    input  entry_t        entry,
    input  logic          is_cg,
    input  logic          shift_right,
    output logic [CW-1:0] start_q
);

    localparam logic [CW-1:0] LAST = CW'(ROWS_LEN - 1);

    logic [CW-1:0] inc_val;
    logic [CW-1:0] dec_val;

    assign inc_val = (start_q == LAST) ? '0 : start_q + 1'b1;
    assign dec_val = (start_q == '0) ? LAST : start_q - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
        end else begin
            case (cmd)
                CMD_CLEAR, CMD_HOME: start_q <= '0;
                CMD_SHIFT_DISP:      start_q <= shift_right ? dec_val : inc_val;
                CMD_DATA: begin
                    if (entry.auto_shift && !is_cg)
                        start_q <= entry.up ? inc_val : dec_val;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dd_scan_map.sv
module dd_scan_map
    import dd_addr_pkg::*;
#(
    parameter int ROWS_LEN = ROW_LEN,
    parameter int CW       = COL_W
) (
    input  logic [CW-1:0] start,
    input  logic          row,
    input  logic [CW-1:0] col,
    output logic [CW:0]   addr
);

    localparam int SW    = CW + 1;
    localparam int MAXS  = (ROWS_LEN - 1) + ((1 << CW) - 1);
    localparam int NSUB  = MAXS / ROWS_LEN;

    logic [SW-1:0] stage [NSUB+1];

    assign stage[0] = {1'b0, start} + {1'b0, col};

    for (genvar i = 0; i < NSUB; i++) begin : g_mod
        assign stage[i+1] = (stage[i] >= SW'(ROWS_LEN)) ? stage[i] - SW'(ROWS_LEN)
                                                        : stage[i];
    end

    assign addr = {row, stage[NSUB][CW-1:0]};

endmodule

// File: rtl/dd_addr_counter.sv
module dd_addr_counter
    import dd_addr_pkg::*;
#(
    parameter int ROWS_LEN = ROW_LEN,
    parameter int AW       = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_addr_stb,
    input  logic          set_addr_cg,
    input  logic [AW-1:0] set_addr_val,
    input  logic          clear_stb,
    input  logic          home_stb,
    input  logic          entry_stb,
    input  logic          entry_up,
    input  logic          entry_shift,
    input  logic          shift_stb,
    input  logic          shift_display,
    input  logic          shift_right,
    input  logic          data_stb,
    input  logic          scan_row,
    input  logic [AW-2:0] scan_col,
    output logic [AW-1:0] mem_addr,
    output logic          mem_is_cg,
    output logic [AW-1:0] cursor_addr,
    output logic          cursor_on,
    output logic [AW-1:0] scan_addr
);

    localparam int CW = AW - 1;

    cmd_e          cmd;
    logic [AW-1:0] ac_q;
    logic          is_cg_q;
    entry_t        entry_q;
    logic [CW-1:0] start_q;

    dd_cmd_decode u_dec (
        .clear_stb     (clear_stb),
        .home_stb      (home_stb),
        .set_addr_stb  (set_addr_stb),
        .entry_stb     (entry_stb),
        .shift_stb     (shift_stb),
        .shift_display (shift_display),
        .data_stb      (data_stb),
        .cmd           (cmd)
    );

    dd_ac_unit #(.ROWS_LEN(ROWS_LEN), .AW(AW)) u_ac (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .load_val    (set_addr_val),
        .load_cg     (set_addr_cg),
        .shift_right (shift_right),
        .new_up      (entry_up),
        .new_shift   (entry_shift),
        .ac_q        (ac_q),
        .is_cg_q     (is_cg_q),
        .entry_q     (entry_q)
    );

    dd_start_unit #(.ROWS_LEN(ROWS_LEN), .CW(CW)) u_start (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .entry       (entry_q),
        .is_cg       (is_cg_q),
        .shift_right (shift_right),
        .start_q     (start_q)
    );

    dd_scan_map #(.ROWS_LEN(ROWS_LEN), .CW(CW)) u_scan (
        .start (start_q),
        .row   (scan_row),
        .col   (scan_col),
        .addr  (scan_addr)
    );

    assign mem_addr    = ac_q;
    assign mem_is_cg   = is_cg_q;
    assign cursor_on   = !is_cg_q;
    assign cursor_addr = is_cg_q ? '0 : ac_q;

endmodule

// File: rtl/dd_addr_checker.sv
module dd_addr_checker #(
    parameter int ROWS_LEN = 40,
    parameter int AW       = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          set_addr_stb,
    input logic          clear_stb,
    input logic          home_stb,
    input logic          entry_stb,
    input logic          shift_stb,
    input logic          data_stb,
    input logic [AW-1:0] mem_addr,
    input logic          mem_is_cg,
    input logic          up_q,
    input logic [AW-2:0] start_q
);

    localparam int CW = AW - 1;
    localparam logic [CW-1:0] LAST = CW'(ROWS_LEN - 1);

    // R12: input contract, one command per cycle
    a_r12_one_cmd: assert property (@(posedge clk) disable iff (rst)
        $onehot0({set_addr_stb, clear_stb, home_stb, entry_stb, shift_stb, data_stb}));

    a_r2_row0_to_row1: assert property (@(posedge clk) disable iff (rst)
        (data_stb && !mem_is_cg && up_q && mem_addr == {1'b0, LAST})
        |=> mem_addr == {1'b1, {CW{1'b0}}});

    a_r2_row1_to_row0: assert property (@(posedge clk) disable iff (rst)
        (data_stb && !mem_is_cg && up_q && mem_addr == {1'b1, LAST})
        |=> mem_addr == '0);

    a_r3_row1_down: assert property (@(posedge clk) disable iff (rst)
        (data_stb && !mem_is_cg && !up_q && mem_addr == {1'b1, {CW{1'b0}}})
        |=> mem_addr == {1'b0, LAST});

    a_r2_col_in_window: assert property (@(posedge clk) disable iff (rst)
        !mem_is_cg |-> mem_addr[CW-1:0] <= LAST);

    a_r4_cg_top_wrap: assert property (@(posedge clk) disable iff (rst)
        (data_stb && mem_is_cg && up_q && mem_addr == {1'b0, {CW{1'b1}}})
        |=> mem_addr == '0);

    a_r4_cg_no_row: assert property (@(posedge clk) disable iff (rst)
        mem_is_cg |-> !mem_addr[AW-1]);

    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        clear_stb |=> (mem_addr == '0 && !mem_is_cg && start_q == '0 && up_q));

    a_r9_start_range: assert property (@(posedge clk) disable iff (rst)
        start_q <= LAST);

    a_r11_entry_keeps: assert property (@(posedge clk) disable iff (rst)
        entry_stb |=> ($stable(mem_addr) && $stable(start_q)));

endmodule

bind dd_addr_counter dd_addr_checker #(.ROWS_LEN(ROWS_LEN), .AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .set_addr_stb (set_addr_stb),
    .clear_stb    (clear_stb),
    .home_stb     (home_stb),
    .entry_stb    (entry_stb),
    .shift_stb    (shift_stb),
    .data_stb     (data_stb),
    .mem_addr     (mem_addr),
    .mem_is_cg    (mem_is_cg),
    .up_q         (entry_q.up),
    .start_q      (start_q)
);

// File: tb/dd_addr_counter_test.sv
module dd_addr_counter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       set_addr_stb = 0, set_addr_cg = 0;
    logic [6:0] set_addr_val = '0;
    logic       clear_stb = 0, home_stb = 0;
    logic       entry_stb = 0, entry_up = 0, entry_shift = 0;
    logic       shift_stb = 0, shift_display = 0, shift_right = 0;
    logic       data_stb = 0;
    logic       scan_row = 0;
    logic [5:0] scan_col = '0;
    logic [6:0] mem_addr, cursor_addr, scan_addr;
    logic       mem_is_cg, cursor_on;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state
    logic [6:0] m_ac;
    logic       m_cg;
    logic       m_up;
    logic       m_sh;
    int         m_start;

    always #4 clk = ~clk;

    dd_addr_counter uut (
        .clk, .rst, .set_addr_stb, .set_addr_cg, .set_addr_val,
        .clear_stb, .home_stb, .entry_stb, .entry_up, .entry_shift,
        .shift_stb, .shift_display, .shift_right, .data_stb,
        .scan_row, .scan_col, .mem_addr, .mem_is_cg,
        .cursor_addr, .cursor_on, .scan_addr
    );

    function automatic logic [6:0] f_step(logic [6:0] a, logic cg, logic up);
        int c = a[5:0];
        if (cg) return {1'b0, up ? 6'(c + 1) : 6'(c - 1)};
        if (up) return (c == 39) ? {~a[6], 6'd0}  : {a[6], 6'(c + 1)};
        return         (c == 0)  ? {~a[6], 6'd39} : {a[6], 6'(c - 1)};
    endfunction

    function automatic logic [6:0] f_load(logic [6:0] v, logic cg);
        int c = v[5:0];
        if (cg) return {1'b0, v[5:0]};
        if (c >= 40) c -= 40;
        return {v[6], 6'(c)};
    endfunction

    function automatic logic [6:0] f_scan(int st, logic row, int col);
        return {row, 6'((st + col) % 40)};
    endfunction

    task automatic check(string req, logic [6:0] act, logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(string req);
        check(req, mem_addr, m_ac);
        check(req, {6'd0, mem_is_cg}, {6'd0, m_cg});
        check({req, "/R10"}, {6'd0, cursor_on}, {6'd0, !m_cg});
        check({req, "/R10"}, cursor_addr, m_cg ? 7'd0 : m_ac);
        check({req, "/R9"}, scan_addr, f_scan(m_start, scan_row, scan_col));
    endtask

    // Issue one command (kind 0 none,1 clear,2 home,3 set,4 entry,5 shift,6 data)
    task automatic issue(int kind, logic [6:0] v, logic a, logic b, string req);
        @(negedge clk);
        case (kind)
            1: clear_stb = 1;
            2: home_stb = 1;
            3: begin set_addr_stb = 1; set_addr_cg = a; set_addr_val = v; end
            4: begin entry_stb = 1; entry_up = a; entry_shift = b; end
            5: begin shift_stb = 1; shift_display = a; shift_right = b; end
            6: data_stb = 1;
            default: ;
        endcase
        @(posedge clk);
        case (kind)
            1: begin m_ac = 0; m_cg = 0; m_up = 1; m_start = 0; end
            2: begin m_ac = 0; m_cg = 0; m_start = 0; end
            3: begin m_ac = f_load(v, a); m_cg = a; end
            4: begin m_up = a; m_sh = b; end
            5: if (a) m_start = b ? (m_start + 39) % 40 : (m_start + 1) % 40;
               else    m_ac = f_step(m_ac, m_cg, b);
            6: begin
                if (m_sh && !m_cg) m_start = m_up ? (m_start + 1) % 40 : (m_start + 39) % 40;
                m_ac = f_step(m_ac, m_cg, m_up);
            end
            default: ;
        endcase
        @(negedge clk);
        {clear_stb, home_stb, set_addr_stb, entry_stb, shift_stb, data_stb} = '0;
        scan_row = 1'($urandom);
        scan_col = 6'($urandom % 40);
        #1;
        check_all(req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_ac = 0; m_cg = 0; m_up = 1; m_sh = 0; m_start = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check_all("R1 reset");

        // Directed row edges, upward
        issue(3, 7'h26, 0, 0, "R5 load 26h");
        issue(6, 0, 0, 0, "R2 26h->27h");
        issue(6, 0, 0, 0, "R2 27h->40h");
        issue(3, 7'h67, 0, 0, "R5 load 67h");
        issue(6, 0, 0, 0, "R2 67h->00h");
        // Downward
        issue(4, 0, 0, 0, "R11 entry down");
        issue(3, 7'h40, 0, 0, "R5 load 40h");
        issue(6, 0, 0, 0, "R3 40h->27h");
        issue(3, 7'h00, 0, 0, "R5 load 00h");
        issue(6, 0, 0, 0, "R3 00h->67h");
        // Column folding on load
        issue(3, 7'h2D, 0, 0, "R5 fold 2Dh");
        issue(3, 7'h7F, 0, 0, "R5 fold 7Fh");
        // Pattern memory wrap
        issue(3, 7'h40, 1, 0, "R4 cg load 00h");
        issue(6, 0, 0, 0, "R4 cg 00h->3Fh");
        issue(4, 0, 1, 1, "R11 entry up+shift");
        issue(6, 0, 0, 0, "R4 cg 3Fh->00h no scroll");
        // Auto-shift in display memory
        issue(3, 7'h05, 0, 0, "R5 back to dd");
        issue(6, 0, 0, 0, "R7 scroll up");
        issue(4, 0, 0, 1, "R11 entry down+shift");
        issue(6, 0, 0, 0, "R7 scroll down");
        issue(6, 0, 0, 0, "R7 scroll down wrap");
        // Shift commands
        issue(5, 0, 1, 1, "R8 display right");
        issue(5, 0, 1, 0, "R8 display left");
        issue(5, 0, 0, 1, "R8 cursor right");
        issue(5, 0, 0, 0, "R8 cursor left");
        issue(2, 0, 0, 0, "R6 home");
        issue(1, 0, 0, 0, "R6 clear");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom % 16;
            int kind;
            if (r < 6)       kind = 6;
            else if (r < 8)  kind = 3;
            else if (r < 10) kind = 4;
            else if (r < 13) kind = 5;
            else if (r == 13) kind = (($urandom % 4) == 0) ? 1 : 2;
            else             kind = 0;
            issue(kind, 7'($urandom), 1'($urandom % 5 == 0 ? 1 : 0) | (kind != 3 ? 1'($urandom) : 1'b0),
                  1'($urandom), "R12 random");
        end

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule